// File: doc/BRIEF.md
# Interrupt Aggregation and Wake Controller

This block gathers interrupt requests for a small 8-bit processor core. It has three core sources and a bank of peripheral sources. The core sources are an external pin that triggers on an edge, a rollover of an 8-bit timer value, and a port-change pulse. Each event sets a sticky flag. A flag counts as a request only when its own enable bit is set. Peripheral requests are first merged, then pass through a group enable. Everything is then merged into two outputs.

The first output is a wake request for a sleeping core. It does not depend on the global enable. The second output is an interrupt to the CPU, which also needs the global enable and carries a fixed vector address. When the CPU takes the interrupt, the global enable clears itself. A return strobe sets it again.

Software uses a small register port. It writes the control and enable registers, and it clears flags by writing ones. Register reads are combinational.

Top module: `irq_hub`

## Requirements
- R1: After reset the following hold.
  - All flags and all enables are 0.
  - The control register reads 0x20: edge polarity is rising and global enable is off.
  - `wake_req` and `cpu_irq` are 0.
  - `vec_addr` is 0x0004.
- R2: `ext_pin` passes through a two-flop synchronizer. Control bit 5 selects the edge: 1 means rising, 0 means falling. A selected edge sets core flag bit 0 on the third rising clock edge after the pin changes. The other edge direction sets nothing.
- R3: The timer flag (core flag bit 1) is set on the clock after `tmr_val` goes from 0xFF directly to 0x00. No other transition sets it.
- R4: A one-cycle `port_chg` pulse sets core flag bit 2. A pulse on `periph_req[i]` sets peripheral flag bit i. Every flag stays set until software clears it.
- R5: A write to address 1 (core flags) or address 3 (peripheral flags) clears each bit written as 1 and leaves bits written as 0 unchanged. If hardware sets a flag in the same cycle that software clears it, the set wins.
- R6: `wake_req` is 1 when either of these holds, regardless of the global enable:
  - any core flag is set together with its enable (control bits 0..2);
  - group enable (control bit 3) is set and any peripheral flag is set together with its bit in the peripheral enable register (address 2).
- R7: `cpu_irq` equals `wake_req` ANDed with the global enable (control bit 4).
- R8: `vec_addr` is always 0x0004.
  - If `irq_take` is high while `cpu_irq` is high, the global enable is 0 from the next cycle.
  - Otherwise, an `irq_reti` pulse sets the global enable.
- R9: Register map:
  - address 0 is control, with bits 5..0 as described above;
  - address 1 holds core flags in bits 2..0;
  - address 2 holds the peripheral enables;
  - address 3 holds the peripheral flags.
  - Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_val | input | 8 | Current value of the 8-bit timer |
| port_chg | input | 1 | One-cycle port-change event |
| periph_req | input | NPER | One-cycle peripheral request pulses |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_take | input | 1 | CPU accepts the interrupt |
| irq_reti | input | 1 | Return-from-interrupt strobe |
| wake_req | output | 1 | Wake request to a sleeping core |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 13 | Fixed interrupt vector address |

## Verification
The assertions check on every cycle that:
- flags are sticky;
- a hardware set beats a clear in the same cycle;
- edge and rollover events last one cycle;
- `cpu_irq` never rises without `wake_req`;
- taking an interrupt drops `cpu_irq` on the next cycle.

Only the bench scenarios can show:
- the synchronizer latency and the effect of the polarity bit;
- that only a 0xFF to 0x00 step counts as a rollover;
- the full gating truth table, swept over every control value and every peripheral enable pattern;
- the register layout.

// File: rtl/irq_pkg.sv
// Package for the interrupt hub: register selects and control bit positions.
// Assumes at most 8 peripheral sources so each bank fits one 8-bit register.
package irq_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_CFLAG = 2'd1,
        SEL_PEN   = 2'd2,
        SEL_PFLAG = 2'd3
    } reg_sel_e;

    localparam int CORE_SRCS  = 3;
    localparam int BIT_GRP_EN = 3;
    localparam int BIT_GLOBAL = 4;
    localparam int BIT_RISE   = 5;
    localparam int CTRL_W     = 6;
    localparam logic [CTRL_W-1:0] CTRL_RST = 6'h20;
endpackage

// File: rtl/irq_pin_edge.sv
// Synchronizes an asynchronous pin with two flops, then detects the edge
// chosen by rise_sel. edge_hit is a single-cycle pulse.
// Assumes the pin is held low through reset.
module irq_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_hit
);
    logic s1, s2, prev;

    // synchronizer chain plus delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= pin;
            s2   <= s1;
            prev <= s2;
        end
    end

    // polarity-selected edge
    always_comb edge_hit = rise_sel ? (s2 & ~prev) : (~s2 & prev);

    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> !edge_hit);
endmodule

// File: rtl/irq_tmr_roll.sv
// Watches an 8-bit timer value and pulses roll when it steps from the
// all-ones value straight to zero. Assumes the timer advances at most once per clock.
module irq_tmr_roll #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cur,
    output logic          roll
);
    logic [TW-1:0] last;

    // remember the previous timer value
    always_ff @(posedge clk) begin
        if (!rst_n) last <= '0;
        else        last <= cur;
    end

    // rollover: previous value was all ones, current value is zero
    always_comb roll = (&last) && (cur == '0);

    p_roll_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> !roll);
endmodule

// File: rtl/irq_flag_bank.sv
// A bank of sticky flags. A set input beats a clear input in the same cycle.
// Assumes set and clr are synchronous to clk.
module irq_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flag
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // one sticky cell: set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr[i]) flag[i] <= 1'b0;
        end

        p_hw_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flag[i]);
        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !clr[i]) |=> flag[i]);
    end
endmodule

// File: rtl/irq_hub.sv
// Interrupt aggregation and wake controller. It collects the core sources
// (edge pin, timer rollover, port change) and NPER peripheral pulses into sticky
// flags. It gates them with enables, a peripheral group enable and a global enable.
// The global enable clears on irq_take and is set again by irq_reti.
// Assumes NPER <= 8.
module irq_hub
    import irq_pkg::*;
#(
    parameter int          NPER = 4,
    parameter int          TW   = 8,
    parameter logic [12:0] VEC  = 13'h0004
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_pin,
    input  logic [TW-1:0]   tmr_val,
    input  logic            port_chg,
    input  logic [NPER-1:0] periph_req,
    input  logic [1:0]      reg_addr,
    input  logic            reg_wr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic            irq_take,
    input  logic            irq_reti,
    output logic            wake_req,
    output logic            cpu_irq,
    output logic [12:0]     vec_addr
);
    localparam int PAD_P = 8 - NPER;
    localparam int PAD_C = 8 - CORE_SRCS;
    localparam int PAD_K = 8 - CTRL_W;

    reg_sel_e              sel;
    logic [CTRL_W-1:0]     ctrl;
    logic [NPER-1:0]       pen;
    logic                  ext_hit, tmr_hit;
    logic [CORE_SRCS-1:0]  core_set, core_clr, core_flag;
    logic [NPER-1:0]       per_clr, per_flag;
    logic                  core_any, per_any;

    always_comb sel = reg_sel_e'(reg_addr);

    irq_pin_edge u_pin (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .rise_sel(ctrl[BIT_RISE]), .edge_hit(ext_hit)
    );

    irq_tmr_roll #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .cur(tmr_val), .roll(tmr_hit)
    );

    // clear strobes from write-one-to-clear accesses
    always_comb begin
        core_set = {port_chg, tmr_hit, ext_hit};
        core_clr = (reg_wr && sel == SEL_CFLAG) ? reg_wdata[CORE_SRCS-1:0] : '0;
        per_clr  = (reg_wr && sel == SEL_PFLAG) ? reg_wdata[NPER-1:0] : '0;
    end

    irq_flag_bank #(.W(CORE_SRCS)) u_core (
        .clk(clk), .rst_n(rst_n), .set(core_set), .clr(core_clr), .flag(core_flag)
    );

    irq_flag_bank #(.W(NPER)) u_per (
        .clk(clk), .rst_n(rst_n), .set(periph_req), .clr(per_clr), .flag(per_flag)
    );

    // control register; the global enable responds to take and return first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RST;
        end else begin
            if (reg_wr && sel == SEL_CTRL) ctrl <= reg_wdata[CTRL_W-1:0];
            if (irq_take && cpu_irq)       ctrl[BIT_GLOBAL] <= 1'b0;
            else if (irq_reti)             ctrl[BIT_GLOBAL] <= 1'b1;
        end
    end

    // peripheral enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                      pen <= '0;
        else if (reg_wr && sel == SEL_PEN) pen <= reg_wdata[NPER-1:0];
    end

    // request merging: wake ignores the global enable, the CPU request needs it
    always_comb begin
        core_any = |(core_flag & ctrl[CORE_SRCS-1:0]);
        per_any  = ctrl[BIT_GRP_EN] & (|(per_flag & pen));
        wake_req = core_any | per_any;
        cpu_irq  = wake_req & ctrl[BIT_GLOBAL];
        vec_addr = VEC;
    end

    // register read mux
    always_comb begin
        unique case (sel)
            SEL_CTRL:  reg_rdata = {{PAD_K{1'b0}}, ctrl};
            SEL_CFLAG: reg_rdata = {{PAD_C{1'b0}}, core_flag};
            SEL_PEN:   reg_rdata = {{PAD_P{1'b0}}, pen};
            default:   reg_rdata = {{PAD_P{1'b0}}, per_flag};
        endcase
    end

    p_irq_implies_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> wake_req);
    p_take_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && cpu_irq) |=> !cpu_irq);
    p_wake_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !reg_wr) |=> wake_req);
endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
    localparam int CLK_PERIOD = 10;
    localparam int NPER = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ext_pin = 1'b0;
    logic [7:0]      tmr_val = 8'h00;
    logic            port_chg = 1'b0;
    logic [NPER-1:0] periph_req = '0;
    logic [1:0]      reg_addr = 2'd0;
    logic            reg_wr = 1'b0;
    logic [7:0]      reg_wdata = 8'h00;
    logic [7:0]      reg_rdata;
    logic            irq_take = 1'b0;
    logic            irq_reti = 1'b0;
    logic            wake_req, cpu_irq;
    logic [12:0]     vec_addr;

    int n_chk = 0;
    int n_fail = 0;

    irq_hub #(.NPER(NPER)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_val(tmr_val),
        .port_chg(port_chg), .periph_req(periph_req), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_take(irq_take), .irq_reti(irq_reti), .wake_req(wake_req),
        .cpu_irq(cpu_irq), .vec_addr(vec_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl reset", d, 8'h20);
        rd(2'd1, d); chk("R1 core flags reset", d, 8'h00);
        rd(2'd2, d); chk("R1 pen reset", d, 8'h00);
        rd(2'd3, d); chk("R1 periph flags reset", d, 8'h00);
        chk("R1 wake reset", wake_req, 0);
        chk("R1 irq reset", cpu_irq, 0);
        chk("R8 vector", vec_addr, 13'h0004);

        // R2 rising edge: flag appears on the third clock edge
        ext_pin = 1'b1;
        tick(2); rd(2'd1, d); chk("R2 sync latency", d[0], 0);
        tick(1); rd(2'd1, d); chk("R2 rising sets", d[0], 1);
        wr(2'd1, 8'h01); rd(2'd1, d); chk("R5 w1c ext", d[0], 0);
        ext_pin = 1'b0; tick(4);
        rd(2'd1, d); chk("R2 falling ignored in rising mode", d[0], 0);
        wr(2'd0, 8'h00);
        ext_pin = 1'b1; tick(4);
        rd(2'd1, d); chk("R2 rising ignored in falling mode", d[0], 0);
        ext_pin = 1'b0; tick(4);
        rd(2'd1, d); chk("R2 falling sets", d[0], 1);
        wr(2'd0, 8'h20); wr(2'd1, 8'h07);

        // R3 timer rollover
        tmr_val = 8'h7F; tick(1); tmr_val = 8'h80; tick(1);
        tmr_val = 8'hFF; tick(1); tmr_val = 8'hFE; tick(1);
        tmr_val = 8'hFF; tick(1); tmr_val = 8'h01; tick(2);
        rd(2'd1, d); chk("R3 no false rollover", d[1], 0);
        tmr_val = 8'hFF; tick(1); tmr_val = 8'h00; tick(1);
        rd(2'd1, d); chk("R3 rollover sets", d[1], 1);
        wr(2'd1, 8'h02);

        // R4 port change and peripherals, sticky
        port_chg = 1'b1; tick(1); port_chg = 1'b0; tick(5);
        rd(2'd1, d); chk("R4 port flag sticky", d[2], 1);
        for (int i = 0; i < NPER; i++) begin
            periph_req = NPER'(1 << i); tick(1); periph_req = '0; tick(2);
            rd(2'd3, d); chk("R4 periph flag", d, 8'((2 << i) - 1));
        end

        // R5 zero write keeps, one write clears, set beats clear
        wr(2'd3, 8'h00); rd(2'd3, d); chk("R5 zero write keeps", d, 8'h0F);
        wr(2'd3, 8'h05); rd(2'd3, d); chk("R5 w1c partial", d, 8'h0A);
        periph_req = 4'b0001; wr(2'd3, 8'h0F); periph_req = '0;
        rd(2'd3, d); chk("R5 set wins over clear", d, 8'h01);

        // R6/R7 sweep: all core flags plus periph flag 0 set
        ext_pin = 1'b1; tmr_val = 8'hFF; tick(1); tmr_val = 8'h00;
        port_chg = 1'b1; tick(1); port_chg = 1'b0; tick(3);
        rd(2'd1, d); chk("R9 core flags all", d, 8'h07);
        for (int c = 0; c < 32; c++) begin
            for (int p = 0; p < 16; p++) begin
                logic ew;
                wr(2'd0, 8'(8'h20 | c));
                wr(2'd2, 8'(p));
                ew = (|(c & 7)) | (c[3] & p[0]);
                chk("R6 wake sweep", wake_req, ew);
                chk("R7 irq sweep", cpu_irq, ew & c[4]);
            end
        end
        // only peripheral flags remain
        wr(2'd1, 8'h07); periph_req = 4'b1010; tick(1); periph_req = '0;
        for (int c = 0; c < 32; c++) begin
            for (int p = 0; p < 16; p++) begin
                logic ew;
                wr(2'd0, 8'(8'h20 | c));
                wr(2'd2, 8'(p));
                ew = c[3] & (|(p & 4'b1011));
                chk("R6 periph wake sweep", wake_req, ew);
                chk("R7 periph irq sweep", cpu_irq, ew & c[4]);
            end
        end

        // R8 take clears global enable, return sets it
        wr(2'd2, 8'h01); wr(2'd0, 8'h38);
        chk("R8 irq before take", cpu_irq, 1);
        irq_take = 1'b1; tick(1); irq_take = 1'b0;
        chk("R8 irq after take", cpu_irq, 0);
        chk("R6 wake survives take", wake_req, 1);
        rd(2'd0, d); chk("R9 ctrl after take", d, 8'h28);
        irq_reti = 1'b1; tick(1); irq_reti = 1'b0;
        chk("R8 irq after reti", cpu_irq, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule